// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Timer

This block is a single down-counting timer channel that turns each trigger into one output pulse of programmable length. Software sets a reload value and a start bit through a small register write port. The next trigger makes the output go high and starts the counter. The counter decrements once on every cycle where the count-source enable `tick_i` is high. When the count runs out, the output drops, the counter reloads and waits, and an interrupt flag latches.

A trigger that arrives while a pulse is running stretches that pulse. On the next tick the counter takes one more step and then reloads, and the output stays high throughout. A mode bit can keep the pulse off the pin, so the channel can serve as a silent internal timer that only raises its interrupt. A reload value of zero disables the channel: triggers then have no effect.

The write port has two registers, selected by `wr_addr_i`. Address 0 is the reload value. Address 1 is control: bit 0 arms counting, bit 1 lets the pulse reach the pin, and writing 1 to bit 2 clears the interrupt flag. Bit 2 is not stored. All inputs are sampled on the rising edge of `clk`. Every input is a single-cycle strobe or a level, so the block has no back-pressure.

Top module: `oneshot_timer`

## Requirements
- R1: After reset `pulse_o`, `pulse_oe_o` and `irq_o` are 0, the channel is disarmed and the reload value is 0.
- R2: A trigger while the control arm bit (bit 0) is 0 starts nothing: `pulse_o` stays low and `irq_o` stays low.
- R3: With the channel armed and a non-zero reload, a trigger makes `pulse_o` high from the next cycle. The count then falls by one only on cycles where `tick_i` is high, and idle cycles leave the pulse running.
- R4: On the tick that brings the count to zero, `pulse_o` drops at that same edge and the counter reloads and stops. The pulse therefore lasts exactly the reload value in ticks, and a later trigger starts a new identical pulse.
- R5: `irq_o` rises at the same edge where the count reaches zero. It then holds until `irq_ack_i` is high or a control write sets bit 2. A terminal count in the same cycle as a clear wins, so the flag stays set.
- R6: With a reload value of 0, a trigger produces no pulse and no interrupt.
- R7: A trigger during a pulse, issued after k ticks, causes one more decrement on the next tick, followed by a reload. The pulse stays high and lasts k+1+reload ticks in total.
- R8: A second trigger that arrives before the next tick following a retrigger is ignored.
- R9: `pulse_oe_o` follows control bit 1. While it is 0, `pulse_o` stays low, and counting and the interrupt behave exactly as with the pin enabled.
- R10: A reload write while stopped loads both the reload register and the counter. A reload write during a pulse changes only the reload register, so the running pulse keeps its length and the next pulse uses the new value.
- R11: A control write with bit 0 clear stops counting at once. `pulse_o` is low from the next cycle, and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-source enable; the counter steps on cycles where it is high |
| trig_i | input | 1 | Synchronous trigger strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 selects reload, 1 selects control |
| wr_data_i | input | W (16) | Write data |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears `irq_o` |
| pulse_o | output | 1 | One-shot pulse output |
| pulse_oe_o | output | 1 | Pin drive enable for the pulse |
| irq_o | output | 1 | Latched interrupt request |

## Verification
The run flag sits one register behind `trig_i`, so the bench expects `pulse_o` high at the first falling edge after the trigger edge. The bench expects the drop of `pulse_o` and the rise of `irq_o` at the falling edge that follows the final tick. A disarm write or an acknowledge shows one falling edge later. Inputs change on falling edges, and every check is sampled on a falling edge just before new inputs are applied. Pulse lengths are measured in ticks applied while `pulse_o` was high, never in clock cycles, so idle cycles inserted between ticks cannot hide a counting error.

// File: rtl/ost_pkg.sv
package ost_pkg;
  localparam logic ADDR_RELOAD = 1'b0;
  localparam logic ADDR_CTRL   = 1'b1;
  localparam int   CTL_ARM     = 0;
  localparam int   CTL_OE      = 1;
  localparam int   CTL_ICLR    = 2;
endpackage

// File: rtl/ost_regs.sv
module ost_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] reload,
  output logic         arm,
  output logic         oe,
  output logic         ld_stb,
  output logic         stop_req,
  output logic         irq_clr
);
  import ost_pkg::*;

  logic ctl_wr;
  assign ctl_wr   = wr_en && (wr_addr == ADDR_CTRL);
  assign ld_stb   = wr_en && (wr_addr == ADDR_RELOAD);
  assign stop_req = !arm || (ctl_wr && !wr_data[CTL_ARM]);
  assign irq_clr  = ctl_wr && wr_data[CTL_ICLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload <= '0;
      arm    <= 1'b0;
      oe     <= 1'b0;
    end else begin
      if (ld_stb) reload <= wr_data;
      if (ctl_wr) begin
        arm <= wr_data[CTL_ARM];
        oe  <= wr_data[CTL_OE];
      end
    end
  end
endmodule

// File: rtl/ost_counter.sv
module ost_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         trig,
  input  logic         stop_req,
  input  logic         ld_stb,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] reload,
  output logic         running,
  output logic         pending,
  output logic [W-1:0] cnt,
  output logic         done
);
  localparam logic [W-1:0] ONE = W'(1);

  logic reload_nz;
  assign reload_nz = (reload != '0);
  assign done = running && !stop_req && tick && !pending && (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pending <= 1'b0;
      cnt     <= '0;
    end else if (!running) begin
      pending <= 1'b0;
      if (ld_stb) cnt <= ld_val;
      if (trig && !stop_req && reload_nz) running <= 1'b1;
    end else if (stop_req) begin
      running <= 1'b0;
      pending <= 1'b0;
      cnt     <= reload;
    end else if (tick) begin
      pending <= 1'b0;
      if (pending) begin
        cnt <= reload;
        if (!reload_nz) running <= 1'b0;
      end else if (cnt == ONE) begin
        running <= 1'b0;
        cnt     <= reload;
      end else begin
        cnt <= cnt - ONE;
      end
    end else if (trig && !pending) begin
      pending <= 1'b1;
    end
  end
endmodule

// File: rtl/ost_irq.sv
module ost_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         trig_i,
  input  logic         wr_en_i,
  input  logic         wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         irq_ack_i,
  output logic         pulse_o,
  output logic         pulse_oe_o,
  output logic         irq_o
);
  logic [W-1:0] reload_q;
  logic [W-1:0] cnt_q;
  logic         arm_q, oe_q, ld_stb, stop_req, irq_clr;
  logic         run_q, pend_q, done_ev;

  ost_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en_i),
    .wr_addr  (wr_addr_i),
    .wr_data  (wr_data_i),
    .reload   (reload_q),
    .arm      (arm_q),
    .oe       (oe_q),
    .ld_stb   (ld_stb),
    .stop_req (stop_req),
    .irq_clr  (irq_clr)
  );

  ost_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_i),
    .trig     (trig_i),
    .stop_req (stop_req),
    .ld_stb   (ld_stb),
    .ld_val   (wr_data_i),
    .reload   (reload_q),
    .running  (run_q),
    .pending  (pend_q),
    .cnt      (cnt_q),
    .done     (done_ev)
  );

  ost_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (done_ev),
    .clr   (irq_clr || irq_ack_i),
    .flag  (irq_o)
  );

  assign pulse_o    = run_q && oe_q;
  assign pulse_oe_o = oe_q;

  logic unused_arm;
  assign unused_arm = arm_q;
endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_i,
  input logic         wr_en_i,
  input logic         wr_addr_i,
  input logic [2:0]   wr_ctl,
  input logic         irq_ack_i,
  input logic         pulse_o,
  input logic         pulse_oe_o,
  input logic         irq_o,
  input logic         run_q,
  input logic         pend_q,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] reload_q
);
  logic clr_wr, disarm_wr;
  assign clr_wr    = wr_en_i && wr_addr_i && wr_ctl[2];
  assign disarm_wr = wr_en_i && wr_addr_i && !wr_ctl[0];

  p_pin_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_oe_o |-> !pulse_o);

  p_count_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick_i && !wr_en_i) |=> (cnt_q == $past(cnt_q)));

  p_zero_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && reload_q == '0 && !wr_en_i) |=> !run_q);

  p_irq_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (!run_q && $past(run_q)));

  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_ack_i && !clr_wr) |=> irq_o);

  p_retrig_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && pend_q && tick_i && !wr_en_i && reload_q != '0) |=> run_q);

  p_disarm_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_wr |=> (!run_q && !pulse_o));
endmodule

bind oneshot_timer oneshot_timer_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_ctl     (wr_data_i[2:0]),
  .irq_ack_i  (irq_ack_i),
  .pulse_o    (pulse_o),
  .pulse_oe_o (pulse_oe_o),
  .irq_o      (irq_o),
  .run_q      (run_q),
  .pend_q     (pend_q),
  .cnt_q      (cnt_q),
  .reload_q   (reload_q)
);

// File: tb/oneshot_timer_bench.sv
module oneshot_timer_bench;
  localparam int W = 16;
  localparam int NV = 6;
  // fields: reload[40:25], retrigger-after-k-ticks[24:17], oe[16], expected ticks[15:0]
  localparam logic [40:0] VEC [NV] = '{
    {16'd3, 8'd0, 1'b1, 16'd3},
    {16'd1, 8'd0, 1'b1, 16'd1},
    {16'd5, 8'd2, 1'b1, 16'd8},
    {16'd4, 8'd1, 1'b0, 16'd6},
    {16'd2, 8'd0, 1'b0, 16'd2},
    {16'd6, 8'd4, 1'b1, 16'd11}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, trig_i = 1'b0, wr_en_i = 1'b0, wr_addr_i = 1'b0, irq_ack_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic pulse_o, pulse_oe_o, irq_o;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  oneshot_timer #(.W(W)) u_oneshot_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .trig_i(trig_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .irq_ack_i(irq_ack_i), .pulse_o(pulse_o), .pulse_oe_o(pulse_oe_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic g);
    tick_i = t; trig_i = g;
    @(negedge clk);
    tick_i = 1'b0; trig_i = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [W-1:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic ack();
    irq_ack_i = 1'b1;
    @(negedge clk);
    irq_ack_i = 1'b0;
  endtask

  // ticks until irq rises; hi counts ticks applied while pulse_o was high
  task automatic until_irq(input int k, output int n, output int hi);
    bit done_rt = 1'b0;
    n = 0; hi = 0;
    while (!irq_o && n < 300) begin
      if (k != 0 && n == k && !done_rt) begin step(1'b0, 1'b1); done_rt = 1'b1; end
      if (pulse_o) hi++;
      step(1'b1, 1'b0); n++;
      step(1'b0, 1'b0);
    end
  endtask

  initial begin
    int n, hi;
    repeat (3) @(negedge clk);
    chk(pulse_o == 1'b0, "R1 pulse", int'(pulse_o), 0);
    chk(pulse_oe_o == 1'b0, "R1 oe", int'(pulse_oe_o), 0);
    chk(irq_o == 1'b0, "R1 irq", int'(irq_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset reload of 0 blocks a trigger once armed
    wr(1'b1, 16'h3);
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    chk(pulse_o == 1'b0, "R1 reload zero at reset", int'(pulse_o), 0);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] rl, ex; logic [7:0] kk; logic oe;
      {rl, kk, oe, ex} = VEC[i];
      wr(1'b0, rl);
      wr(1'b1, {14'd0, oe, 1'b1});
      chk(pulse_oe_o == oe, "R9 oe pin", int'(pulse_oe_o), int'(oe));
      step(1'b0, 1'b1);
      chk(pulse_o == oe, "R3 pulse rises after trigger", int'(pulse_o), int'(oe));
      until_irq(int'(kk), n, hi);
      chk(n == int'(ex), (kk != 0) ? "R7 retrigger length" : "R4 pulse length", n, int'(ex));
      chk(hi == (oe ? int'(ex) : 0), "R9 pulse high ticks", hi, oe ? int'(ex) : 0);
      chk(pulse_o == 1'b0 && irq_o == 1'b1, "R5 irq with pulse end", int'(irq_o), 1);
      step(1'b0, 1'b0); step(1'b0, 1'b0);
      chk(irq_o == 1'b1, "R5 irq holds", int'(irq_o), 1);
      ack();
      chk(irq_o == 1'b0, "R5 ack clears", int'(irq_o), 0);
    end

    // R4: re-trigger after an end gives the same pulse again
    wr(1'b0, 16'd3);
    step(1'b0, 1'b1);
    until_irq(0, n, hi);
    chk(n == 3, "R4 second shot", n, 3);
    // R5: control write bit 2 clears
    wr(1'b1, 16'b111);
    chk(irq_o == 1'b0, "R5 soft clear", int'(irq_o), 0);

    // R3: idle cycles between ticks do not count
    step(1'b0, 1'b1);
    repeat (6) step(1'b0, 1'b0);
    chk(pulse_o == 1'b1, "R3 idle keeps pulse", int'(pulse_o), 1);
    until_irq(0, n, hi);
    chk(n == 3, "R3 ticks only", n, 3);
    ack();

    // R2: disarmed trigger ignored
    wr(1'b1, 16'b010);
    step(1'b0, 1'b1);
    chk(pulse_o == 1'b0, "R2 disarmed pulse", int'(pulse_o), 0);
    repeat (5) begin step(1'b1, 1'b0); step(1'b0, 1'b0); end
    chk(irq_o == 1'b0, "R2 disarmed irq", int'(irq_o), 0);

    // R6: zero reload
    wr(1'b0, 16'd0);
    wr(1'b1, 16'b011);
    step(1'b0, 1'b1);
    chk(pulse_o == 1'b0, "R6 zero reload pulse", int'(pulse_o), 0);
    repeat (8) begin step(1'b1, 1'b0); step(1'b0, 1'b0); end
    chk(irq_o == 1'b0, "R6 zero reload irq", int'(irq_o), 0);

    // R11: disarm mid-pulse
    wr(1'b0, 16'd6);
    step(1'b0, 1'b1);
    step(1'b1, 1'b0); step(1'b1, 1'b0);
    chk(pulse_o == 1'b1, "R11 running before disarm", int'(pulse_o), 1);
    wr(1'b1, 16'b010);
    chk(pulse_o == 1'b0, "R11 pulse low after disarm", int'(pulse_o), 0);
    repeat (10) begin step(1'b1, 1'b0); step(1'b0, 1'b0); end
    chk(irq_o == 1'b0, "R11 no irq", int'(irq_o), 0);

    // R10: reload write during a pulse
    wr(1'b0, 16'd4);
    wr(1'b1, 16'b011);
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    wr(1'b0, 16'd9);
    until_irq(0, n, hi);
    chk(n == 3, "R10 running pulse unchanged", n + 1, 4);
    ack();
    step(1'b0, 1'b1);
    until_irq(0, n, hi);
    chk(n == 9, "R10 next pulse uses new value", n, 9);
    ack();

    // R8: double trigger within one tick period
    wr(1'b0, 16'd5);
    step(1'b0, 1'b1);
    step(1'b1, 1'b0); step(1'b1, 1'b0);
    step(1'b0, 1'b1); step(1'b0, 1'b1);
    until_irq(0, n, hi);
    chk(n + 2 == 8, "R8 second trigger ignored", n + 2, 8);
    ack();

    // R5: terminal count wins over same-cycle acknowledge
    wr(1'b0, 16'd1);
    step(1'b0, 1'b1);
    irq_ack_i = 1'b1;
    step(1'b1, 1'b0);
    irq_ack_i = 1'b0;
    chk(irq_o == 1'b1, "R5 set wins over clear", int'(irq_o), 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule